// File: doc/BRIEF.md
# Multiphase Phase-Count Detector

At start-up this block works out how many phases a multiphase supply actually has fitted. There is a main rail with up to six phases and an auxiliary rail with up to two. Each phase position has a comparator flag that reads 1 when the current-sense input of that phase is pulled up to the supply, which marks the position as unfitted. After a start strobe the block watches all flags for a fixed detection window, timed by a microsecond tick. When the window ends it reports the phase count of each rail, a per-phase enable mask and a configuration-error bit, and raises a done flag.

The count of each rail stops at the lowest position whose flag stays high for the whole window. On the main rail, pulling phase N+1 high leaves phases 1 to N. On the auxiliary rail, pulling the second position high gives one phase, and pulling the first position high gives zero phases. This covers the main configurations 6, 5, 4, 3 and 2 and the auxiliary configurations 2, 1 and 0. The results stay latched until the next start strobe.

Top module: `rail_phase_probe`

## Requirements
- R1: After reset, done, both counts, the enable mask and the configuration-error output are all 0.
- R2: Done goes to 1 on the clock edge that accepts the 1500th tick after the start strobe, and stays 0 before that edge. A start strobe clears done on the next edge.
- R3: The main count is the 0-based index of the lowest main flag (bit 0 = phase 1) that stayed high through the whole window. Flags above that index are ignored.
- R4: If no main flag stays high through the whole window, the main count is 6.
- R5: The auxiliary count is 0 when auxiliary flag bit 0 stays high. It is 1 when only bit 1 stays high. It is 2 when neither stays high.
- R6: A flag that is low on any sampled cycle of the window marks its phase as fitted. This includes a flag that drops for a single cycle and a flag that rises late in the window.
- R7: Enable mask bits [5:0] hold one 1 for each counted main phase, packed from bit 0 upward. Bits [7:6] do the same for the auxiliary phases, starting at bit 6.
- R8: The configuration-error output is 1 exactly when the reported main count is below 2, which happens when the phase 1 or phase 2 flag is held high.
- R9: Once done is 1, the outputs do not change while the flags change. A start strobe during a window restarts it, and the full window is timed again from that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle strobe that begins a detection window |
| tick_us_i | input | 1 | One-cycle pulse every microsecond |
| main_sense_i | input | 6 | Main-rail pulled-high flags, bit 0 = phase 1 |
| aux_sense_i | input | 2 | Auxiliary-rail pulled-high flags, bit 0 = first phase |
| main_count_o | output | 3 | Number of main-rail phases detected |
| aux_count_o | output | 2 | Number of auxiliary-rail phases detected |
| phase_en_o | output | 8 | Per-phase enable mask: main in [5:0], auxiliary in [7:6] |
| cfg_err_o | output | 1 | Main count below the supported minimum |
| done_o | output | 1 | Results valid |

## Verification
The tests use the following flag patterns, each aimed at one question:
- No flags set checks the full 6+2 result and the exact edge on which done rises.
- A single high flag at phase 5 shows the count stopping at the right place.
- Flags at phases 4 and 6 show that higher flags are ignored once the count has stopped.
- The three auxiliary patterns separate the zero-phase case from the one-phase case.
- A flag that dips for one cycle, and a flag that rises late in the window, show that a flag must be held for the whole window to count.
- Flags at phase 1, phase 2 and phase 3 mark the edge of the configuration error.
- Changing the flags after done, and restarting in the middle of a window, cover the latching and restart behaviour.

// File: rtl/rail_phase_pkg.sv
package rail_phase_pkg;

  localparam int MAX_LANES = 16;

  // index of the lowest set bit among the first n bits, or n when none is set
  function automatic int first_high(input logic [MAX_LANES-1:0] held, input int n);
    int pos;
    pos = n;
    for (int i = n - 1; i >= 0; i--) begin
      if (held[i]) pos = i;
    end
    return pos;
  endfunction

  // k ones packed from bit 0
  function automatic logic [MAX_LANES-1:0] low_ones(input int k);
    logic [MAX_LANES-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_LANES; i++) begin
      if (i < k) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/phase_window_timer.sv
module phase_window_timer #(
  parameter int WINDOW_TICKS = 1500,
  localparam int CW = $clog2(WINDOW_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic window_end
);
  logic [CW-1:0] tick_cnt;

  assign window_end = busy && !start && tick && (tick_cnt == CW'(WINDOW_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      tick_cnt <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      tick_cnt <= '0;
    end else if (window_end) begin
      busy     <= 1'b0;
      tick_cnt <= '0;
    end else if (busy && tick) begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end

  // R2: the tick count never reaches the window length while busy
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tick_cnt < CW'(WINDOW_TICKS)));

  // R2: the window closes after its final tick
  p_end_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    window_end |=> !busy);

endmodule

// File: rtl/phase_flag_tracker.sv
module phase_flag_tracker #(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             busy,
  input  logic [LANES-1:0] flags,
  output logic [LANES-1:0] held_now
);
  logic [LANES-1:0] held;

  // includes the sample taken in the current cycle
  assign held_now = held & flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held <= '0;
    else if (start) held <= '1;
    else if (busy)  held <= held_now;
  end

  // R6: once a lane has been seen low inside a window it never comes back
  p_held_monotone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> ((held & ~$past(held)) == '0));

endmodule

// File: rtl/phase_result_latch.sv
module phase_result_latch
  import rail_phase_pkg::*;
#(
  parameter int MAIN_PHASES = 6,
  parameter int AUX_PHASES  = 2,
  parameter int MIN_MAIN    = 2,
  localparam int MCW = $clog2(MAIN_PHASES + 1),
  localparam int ACW = $clog2(AUX_PHASES + 1),
  localparam int LANES = MAIN_PHASES + AUX_PHASES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             window_end,
  input  logic [LANES-1:0] held_now,
  output logic [MCW-1:0]   main_cnt,
  output logic [ACW-1:0]   aux_cnt,
  output logic [LANES-1:0] phase_en,
  output logic             cfg_err,
  output logic             done
);
  int                     main_pos;
  int                     aux_pos;
  logic [MAIN_PHASES-1:0] main_mask;
  logic [AUX_PHASES-1:0]  aux_mask;

  always_comb begin
    main_pos  = first_high(MAX_LANES'(held_now[MAIN_PHASES-1:0]), MAIN_PHASES);
    aux_pos   = first_high(MAX_LANES'(held_now[LANES-1:MAIN_PHASES]), AUX_PHASES);
    main_mask = MAIN_PHASES'(low_ones(main_pos));
    aux_mask  = AUX_PHASES'(low_ones(aux_pos));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_cnt <= '0;
      aux_cnt  <= '0;
      phase_en <= '0;
      cfg_err  <= 1'b0;
      done     <= 1'b0;
    end else if (start) begin
      main_cnt <= '0;
      aux_cnt  <= '0;
      phase_en <= '0;
      cfg_err  <= 1'b0;
      done     <= 1'b0;
    end else if (window_end) begin
      main_cnt <= MCW'(main_pos);
      aux_cnt  <= ACW'(aux_pos);
      phase_en <= {aux_mask, main_mask};
      cfg_err  <= (main_pos < MIN_MAIN);
      done     <= 1'b1;
    end
  end

  // R9: results hold until the next start
  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(main_cnt) && $stable(aux_cnt) && $stable(phase_en)));

  // R2: a start strobe clears done
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  // R5: auxiliary count in range
  p_aux_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    aux_cnt <= ACW'(AUX_PHASES));

endmodule

// File: rtl/rail_phase_probe.sv
module rail_phase_probe #(
  parameter int MAIN_PHASES  = 6,
  parameter int AUX_PHASES   = 2,
  parameter int MIN_MAIN     = 2,
  parameter int WINDOW_TICKS = 1500,
  localparam int MCW = $clog2(MAIN_PHASES + 1),
  localparam int ACW = $clog2(AUX_PHASES + 1),
  localparam int LANES = MAIN_PHASES + AUX_PHASES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   tick_us_i,
  input  logic [MAIN_PHASES-1:0] main_sense_i,
  input  logic [AUX_PHASES-1:0]  aux_sense_i,
  output logic [MCW-1:0]         main_count_o,
  output logic [ACW-1:0]         aux_count_o,
  output logic [LANES-1:0]       phase_en_o,
  output logic                   cfg_err_o,
  output logic                   done_o
);
  logic             win_busy;
  logic             win_end;
  logic [LANES-1:0] held_now;

  phase_window_timer #(.WINDOW_TICKS(WINDOW_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_i), .tick(tick_us_i),
    .busy(win_busy), .window_end(win_end)
  );

  phase_flag_tracker #(.LANES(LANES)) u_track (
    .clk(clk), .rst_n(rst_n), .start(start_i), .busy(win_busy),
    .flags({aux_sense_i, main_sense_i}), .held_now(held_now)
  );

  phase_result_latch #(
    .MAIN_PHASES(MAIN_PHASES), .AUX_PHASES(AUX_PHASES), .MIN_MAIN(MIN_MAIN)
  ) u_result (
    .clk(clk), .rst_n(rst_n), .start(start_i), .window_end(win_end),
    .held_now(held_now), .main_cnt(main_count_o), .aux_cnt(aux_count_o),
    .phase_en(phase_en_o), .cfg_err(cfg_err_o), .done(done_o)
  );

  // R7: the main mask population matches the reported main count
  p_mask_main_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones(phase_en_o[MAIN_PHASES-1:0]) == int'(main_count_o)));

  // R7: the auxiliary mask population matches the reported auxiliary count
  p_mask_aux_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones(phase_en_o[LANES-1:MAIN_PHASES]) == int'(aux_count_o)));

  // R8: error output agrees with the reported count
  p_err_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cfg_err_o == (int'(main_count_o) < MIN_MAIN)));

  // R2: done only rises at the close of a window
  p_done_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(win_end));

endmodule

// File: tb/test_rail_phase_probe.sv
module test_rail_phase_probe;
  localparam int W = 1500;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       tick_us_i = 1'b0;
  logic [5:0] main_sense_i = '0;
  logic [1:0] aux_sense_i = '0;
  logic [2:0] main_count_o;
  logic [1:0] aux_count_o;
  logic [7:0] phase_en_o;
  logic       cfg_err_o;
  logic       done_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rail_phase_probe i_rail_phase_probe (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_us_i(tick_us_i),
    .main_sense_i(main_sense_i), .aux_sense_i(aux_sense_i),
    .main_count_o(main_count_o), .aux_count_o(aux_count_o),
    .phase_en_o(phase_en_o), .cfg_err_o(cfg_err_o), .done_o(done_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_count(input int flags, input int n);
    for (int i = 0; i < n; i++) if ((flags >> i) & 1) return i;
    return n;
  endfunction

  function automatic int exp_mask(input int mc, input int ac);
    return (((1 << ac) - 1) << 6) | ((1 << mc) - 1);
  endfunction

  task automatic pulse_start;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic send_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_us_i = 1'b1;
      @(negedge clk) tick_us_i = 1'b0;
    end
  endtask

  task automatic expect_result(input string req, input int mf, input int af);
    int mc;
    int ac;
    mc = exp_count(mf, 6);
    ac = exp_count(af, 2);
    chk({req, " done"}, int'(done_o), 1);
    chk({req, " main count"}, int'(main_count_o), mc);
    chk({req, " aux count"}, int'(aux_count_o), ac);
    chk({req, " mask (R7)"}, int'(phase_en_o), exp_mask(mc, ac));
    chk({req, " error (R8)"}, int'(cfg_err_o), (mc < 2) ? 1 : 0);
  endtask

  task automatic run_static(input string req, input int mf, input int af);
    main_sense_i = 6'(mf);
    aux_sense_i  = 2'(af);
    pulse_start();
    send_ticks(W);
    expect_result(req, mf, af);
  endtask

  task automatic t_reset_r1;
    chk("R1 done", int'(done_o), 0);
    chk("R1 main", int'(main_count_o), 0);
    chk("R1 aux", int'(aux_count_o), 0);
    chk("R1 mask", int'(phase_en_o), 0);
    chk("R1 err", int'(cfg_err_o), 0);
  endtask

  task automatic t_timing_r2_r4;
    main_sense_i = '0;
    aux_sense_i  = '0;
    pulse_start();
    chk("R2 done cleared", int'(done_o), 0);
    send_ticks(W - 1);
    chk("R2 done before last tick", int'(done_o), 0);
    send_ticks(1);
    expect_result("R4", 0, 0);
  endtask

  task automatic t_trunc_r3;
    run_static("R3 phase5 high", 6'b010000, 0);
    run_static("R3 phases 4 and 6 high", 6'b101000, 0);
  endtask

  task automatic t_aux_r5;
    run_static("R5 aux second high", 0, 2'b10);
    run_static("R5 aux first high", 0, 2'b01);
    run_static("R5 aux both high", 0, 2'b11);
  endtask

  task automatic t_glitch_r6;
    main_sense_i = 6'b100000;
    aux_sense_i  = 2'b10;
    pulse_start();
    send_ticks(500);
    @(negedge clk) main_sense_i = 6'b000000;
    @(negedge clk) main_sense_i = 6'b100000;
    send_ticks(W - 500);
    expect_result("R6 dip", 0, 2'b10);
    main_sense_i = '0;
    aux_sense_i  = '0;
    pulse_start();
    send_ticks(10);
    @(negedge clk) aux_sense_i = 2'b01;
    send_ticks(W - 10);
    expect_result("R6 late rise", 0, 0);
  endtask

  task automatic t_err_r8;
    run_static("R8 phase1 high", 6'b000001, 0);
    run_static("R8 phase2 high", 6'b000010, 0);
    run_static("R8 phase3 high", 6'b000100, 0);
  endtask

  task automatic t_hold_restart_r9;
    run_static("R9 base", 6'b001000, 2'b10);
    @(negedge clk) main_sense_i = 6'b000001;
    aux_sense_i = 2'b01;
    send_ticks(20);
    expect_result("R9 hold", 6'b001000, 2'b10);
    main_sense_i = 6'b010000;
    aux_sense_i  = 2'b00;
    pulse_start();
    send_ticks(700);
    @(negedge clk) main_sense_i = 6'b000100;
    pulse_start();
    send_ticks(W - 1);
    chk("R9 restart retimes window", int'(done_o), 0);
    send_ticks(1);
    expect_result("R9 restart", 6'b000100, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset_r1();
        @(negedge clk) rst_n = 1'b1;
        t_timing_r2_r4();
        t_trunc_r3();
        t_aux_r5();
        t_glitch_r6();
        t_err_r8();
        t_hold_restart_r9();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule